// File: doc/BRIEF.md
# Strided DMA Address Generator

This block sequences the addresses for a single DMA channel. A one-cycle start pulse captures a start address on the external side and one on the internal side, an element count, a transfer-size code and an unsigned byte stride. It then offers one beat per element on a valid/ready output. Each beat carries an internal address, an external address and the size code. The internal address always moves on by the size of one transfer. The external address moves on by the stride, which may be zero so that every beat targets the same location, such as a FIFO data port.

Before it runs, the block checks the captured parameters. If the stride or either start address is not a whole multiple of the transfer size, it raises a one-cycle bad-parameter pulse and issues nothing. A transfer finishes with a one-cycle done pulse. Moving the data, the bus protocol and memory attributes are left to the logic around the block.

Top module: `strided_dma_agu`

## Requirements
- R1: While reset is held and after it is released, beat_valid, busy, done and bad_param are all 0.
- R2: A start in idle with legal parameters and count N>0 sets beat_valid from the next cycle. Exactly N beats are transferred, one in each cycle with beat_valid and beat_ready both high. While beat_ready is low, beat_valid stays high and the beat fields hold their values.
- R3: The first beat's external address equals the captured start. Each later beat's external address is the previous one plus the zero-extended stride, so a stride of 0 keeps it fixed.
- R4: The first beat's internal address equals the captured start. Each later beat's internal address is the previous one plus the transfer size in bytes, whatever the stride.
- R5: Size codes are 00=1, 01=2, 10=4 and 11=8 bytes. If the stride, the external start or the internal start is not a multiple of the size, bad_param is 1 for exactly the cycle after start, and no beat and no done follow.
- R6: In the cycle after the last handshake, done is 1 for one cycle, and busy and beat_valid are 0.
- R7: Every beat carries the size code captured at start. Changing the inputs after start has no effect on the running sequence.
- R8: A legal start with count 0 gives done=1 in the next cycle and issues no beat.
- R9: A start pulse while busy is ignored: the running sequence continues unchanged and keeps its beat count.
- R10: Both addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures parameters when idle |
| ext_start | input | 32 | External start address |
| int_start | input | 32 | Internal start address |
| count | input | 16 | Number of beats |
| tsize | input | 2 | Transfer size code |
| stride | input | 12 | External byte stride |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat accepted by consumer |
| beat_ext | output | 32 | External address of beat |
| beat_int | output | 32 | Internal address of beat |
| beat_size | output | 2 | Size code of beat |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_param | output | 1 | One-cycle parameter error pulse |

## Verification
Most wrong internal states reach the ports within a beat. A bad stride or address register shows up at the second handshake as a wrong external or internal address. A wrong remaining count shows up as an early or late done pulse, or as too few or too many beats. A faulty alignment check shows up one cycle after start, as either a missing bad_param pulse or beats that appear when none should. The bench compares a behavioural model with every output on every cycle, under both a ready signal that is always high and one with pseudo-random stalls.

// File: rtl/strided_dma_agu.sv
module strided_dma_agu #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ext_start,
  input  logic [ADDR_W-1:0] int_start,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        tsize,
  input  logic [STRIDE_W-1:0] stride,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_ext,
  output logic [ADDR_W-1:0] beat_int,
  output logic [1:0]        beat_size,
  output logic              busy,
  output logic              done,
  output logic              bad_param
);

  logic                busy_q, done_q, bad_q;
  logic [ADDR_W-1:0]   ext_q, int_q;
  logic [1:0]          size_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [CNT_W-1:0]    left_q;

  logic [3:0] step_in, step_q;
  logic [2:0] mask;
  logic       misaligned, fire, last;

  assign step_in    = 4'd1 << tsize;
  assign step_q     = 4'd1 << size_q;
  assign mask       = 3'(step_in - 4'd1);
  assign misaligned = |((stride[2:0] | ext_start[2:0] | int_start[2:0]) & mask);
  assign fire       = busy_q & beat_ready;
  assign last       = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      bad_q    <= 1'b0;
      ext_q    <= '0;
      int_q    <= '0;
      size_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (busy_q) begin
        if (fire) begin
          ext_q  <= ext_q + ADDR_W'(stride_q);
          int_q  <= int_q + ADDR_W'(step_q);
          left_q <= left_q - CNT_W'(1);
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else if (start) begin
        if (misaligned) begin
          bad_q <= 1'b1;
        end else if (count == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          ext_q    <= ext_start;
          int_q    <= int_start;
          size_q   <= tsize;
          stride_q <= stride;
          left_q   <= count;
        end
      end
    end
  end

  assign beat_valid = busy_q;
  assign busy       = busy_q;
  assign beat_ext   = ext_q;
  assign beat_int   = int_q;
  assign beat_size  = size_q;
  assign done       = done_q;
  assign bad_param  = bad_q;

endmodule

// File: rtl/strided_dma_agu_chk.sv
module strided_dma_agu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_ext,
  input logic [ADDR_W-1:0] beat_int,
  input logic [1:0]        beat_size,
  input logic              busy,
  input logic              done,
  input logic              bad_param
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_ext) && $stable(beat_int) && $stable(beat_size));

  assert_int_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> !beat_valid || (beat_int == $past(beat_int) + (ADDR_W'(1) << $past(beat_size))));

  assert_bad_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_param |-> !done && !busy && !beat_valid);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !beat_valid);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) || $past(start));

  assert_size_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> $stable(beat_size));

endmodule

bind strided_dma_agu strided_dma_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_ext(beat_ext), .beat_int(beat_int),
  .beat_size(beat_size), .busy(busy), .done(done), .bad_param(bad_param)
);

// File: tb/strided_dma_agu_tb.sv
module strided_dma_agu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] ext_start = '0, int_start = '0;
  logic [15:0] count = '0;
  logic [1:0]  tsize = '0;
  logic [11:0] stride = '0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, busy, done, bad_param;
  logic [31:0] beat_ext, beat_int;
  logic [1:0]  beat_size;

  always #10 clk = ~clk;

  strided_dma_agu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_start(ext_start),
    .int_start(int_start), .count(count), .tsize(tsize), .stride(stride),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_ext(beat_ext),
    .beat_int(beat_int), .beat_size(beat_size), .busy(busy), .done(done),
    .bad_param(bad_param)
  );

  int errors = 0, checks = 0, cycles = 0, hs_cnt = 0;
  logic        m_busy = 0, m_done = 0, m_bad = 0;
  logic [31:0] m_ext = 0, m_int = 0;
  logic [1:0]  m_size = 0;
  logic [11:0] m_stride = 0;
  int          m_left = 0;
  logic        stall_mode = 0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bad = 0; m_left = 0;
    end else begin
      m_done = 0; m_bad = 0;
      if (m_busy) begin
        if (beat_ready) begin
          hs_cnt++;
          m_ext = m_ext + {20'd0, m_stride};
          m_int = m_int + (32'd1 << m_size);
          m_left--;
          if (m_left == 0) begin m_busy = 0; m_done = 1; end
        end
      end else if (start) begin
        if ((stride % (1 << tsize)) != 0 || (ext_start % (1 << tsize)) != 0 ||
            (int_start % (1 << tsize)) != 0)
          m_bad = 1;
        else if (count == 0)
          m_done = 1;
        else begin
          m_busy = 1; m_ext = ext_start; m_int = int_start;
          m_size = tsize; m_stride = stride; m_left = int'(count);
        end
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    beat_ready <= stall_mode ? lfsr[0] : 1'b1;
    if (rst_n) begin
      chk(beat_valid == m_busy, "R2 beat_valid", 32'(beat_valid), 32'(m_busy));
      chk(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R6 done", 32'(done), 32'(m_done));
      chk(bad_param == m_bad, "R5 bad_param", 32'(bad_param), 32'(m_bad));
      if (m_busy) begin
        chk(beat_ext == m_ext, "R3 R10 beat_ext", beat_ext, m_ext);
        chk(beat_int == m_int, "R4 R10 beat_int", beat_int, m_int);
        chk(beat_size == m_size, "R7 beat_size", 32'(beat_size), 32'(m_size));
      end
    end
  end

  task automatic run(input logic [31:0] e, input logic [31:0] i, input int n,
                     input logic [1:0] ts, input logic [11:0] st, input bit stall,
                     input bit poke, input int exp_beats);
    @(negedge clk);
    stall_mode = stall; hs_cnt = 0;
    ext_start = e; int_start = i; count = 16'(n); tsize = ts; stride = st; start = 1;
    @(negedge clk);
    start = 0;
    // R7: scramble inputs once captured
    ext_start = ~e; int_start = ~i; count = 16'd3; tsize = ~ts; stride = 12'h008;
    repeat (3) @(negedge clk);
    if (poke) begin
      // R9: start while busy
      tsize = 2'b00; stride = 12'h001; count = 16'd1; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
    chk(hs_cnt == exp_beats, poke ? "R9 beat count" : "R2 beat count", 32'(hs_cnt), 32'(exp_beats));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!beat_valid && !busy && !done && !bad_param, "R1 reset outputs",
        {28'd0, beat_valid, busy, done, bad_param}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!beat_valid && !busy && !done && !bad_param, "R1 after release",
        {28'd0, beat_valid, busy, done, bad_param}, 32'd0);

    run(32'h0000_1000, 32'h0000_8000, 6, 2'b10, 12'd0,   0, 0, 6);   // R3 fixed FIFO
    run(32'h0000_2000, 32'h0000_9000, 8, 2'b10, 12'd12,  1, 0, 8);   // R3 R4 word
    run(32'h0000_3002, 32'h0000_A002, 5, 2'b01, 12'd6,   1, 0, 5);   // halfword
    run(32'h0000_4008, 32'h0000_B010, 4, 2'b11, 12'd16,  0, 0, 4);   // doubleword
    run(32'h0000_5001, 32'h0000_C003, 7, 2'b00, 12'd7,   1, 0, 7);   // byte
    run(32'hFFFF_FFF0, 32'hFFFF_FFF8, 4, 2'b11, 12'h100, 0, 0, 4);   // R10 wrap
    run(32'h0000_6000, 32'h0000_D000, 12, 2'b10, 12'd4,  1, 1, 12);  // R9

    // R5 bad parameters
    run(32'h0000_7000, 32'h0000_E000, 4, 2'b10, 12'd6,   0, 0, 0);
    run(32'h0000_7001, 32'h0000_E000, 4, 2'b01, 12'd2,   0, 0, 0);
    run(32'h0000_7000, 32'h0000_E004, 4, 2'b11, 12'd8,   0, 0, 0);

    // R8 count zero
    @(negedge clk);
    ext_start = 32'h100; int_start = 32'h200; count = 0; tsize = 2'b10; stride = 12'd4; start = 1;
    @(negedge clk);
    start = 0;
    chk(done && !beat_valid, "R8 zero count done", {30'd0, done, beat_valid}, 32'd2);
    @(negedge clk);
    chk(!done && !beat_valid, "R8 zero count quiet", {30'd0, done, beat_valid}, 32'd0);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule